// File: doc/BRIEF.md
# Associative List-Node Cache

This block holds top-level list nodes in a small fully associative store and answers list queries in a fixed two cycles, whatever the length of the list. Each entry keeps an opaque car word, a list tag shared by every node of the same top-level chain, and a position number that counts backwards. The last node of a chain has position 0. The head has position (element count − 1). Every entry is compared against a query at the same time, so indexed access, length and membership need no pointer walk.

A write port loads a node into a chosen slot or invalidates that slot. A query port takes an opcode, a list tag and an operand. It returns a found flag and a result word, qualified by a one-cycle done strobe. The query sees the store as it stands in the cycle the query is issued. A write in that same cycle is not yet visible to it.

Top module: `lnode_cam`

## Requirements
- R1: Reset clears every slot's valid bit. After reset, any query returns found low and result 0.
- R2: When `wr_en` is high, slot `wr_idx` takes the car, tag and position from the write port. It becomes valid if `wr_valid` is 1 and invalid if `wr_valid` is 0. From the next cycle on, queries see the change.
- R3: A query issued with `q_start` high in cycle c raises `r_done` for exactly cycle c+2. `r_done` is never high without a start two cycles earlier.
- R4: Opcode 2'b00 (nth) treats `q_arg` as a zero-based index counted from the head. If the index is below the list length and a node sits at position (length − 1 − index), the result is that node's car and found is high. Otherwise found is low.
- R5: Opcode 2'b01 (length) returns (largest valid position carrying the tag) + 1, and found high. For a tag with no valid node it returns 0 with found low.
- R6: Opcode 2'b10 (memq) sets found when some valid node of the list has car equal to `q_arg`. The result is the head-relative index of the nearest such node to the head.
- R7: Opcode 2'b11 (get) looks for the nearest-to-head node with car equal to `q_arg` at an even head-relative offset. It returns the car of the node whose position is one lower. Found is low if no key sits at an even offset, or if the key node has position 0.
- R8: Invalid slots and slots carrying another tag take no part in any query.
- R9: Whenever found is low at done, the result word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one slot |
| wr_valid | input | 1 | 1 loads the slot, 0 invalidates it |
| wr_idx | input | IDX_W | Slot number written |
| wr_car | input | CAR_W | Car word to store |
| wr_tag | input | TAG_W | List tag to store |
| wr_num | input | NUM_W | Reverse position to store |
| q_start | input | 1 | Issues a query this cycle |
| q_op | input | 2 | 00 nth, 01 length, 10 memq, 11 get |
| q_tag | input | TAG_W | List tag queried |
| q_arg | input | CAR_W | Index for nth, key for memq and get |
| r_done | output | 1 | Result valid, one cycle |
| r_found | output | 1 | Query hit |
| r_data | output | CAR_W | Result word |

## Verification
The bench targets several corner cases, each with a distinct failure signature:
- An index equal to the length. A design that skips the range test wraps the subtraction and returns some other node.
- A tag with no nodes. An off-by-one length would report 1 instead of 0.
- A get key at an odd offset, or on the last node. A design that ignores offset parity, or that reads position −1, returns a stray value as a hit.
- Invalidating the head node. This shortens the list and shifts every offset's parity. A design that still counts the invalid slot reports the old length and the old get pairing.

Random lists with repeated car values check that memq and get pick the match nearest the head.

// File: rtl/lnode_cam.sv
module lnode_cam #(
  parameter int ENTRIES = 16,
  parameter int CAR_W   = 16,
  parameter int TAG_W   = 6,
  parameter int NUM_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LEN_W  = NUM_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CAR_W-1:0] wr_car,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [NUM_W-1:0] wr_num,
  input  logic             q_start,
  input  logic [1:0]       q_op,
  input  logic [TAG_W-1:0] q_tag,
  input  logic [CAR_W-1:0] q_arg,
  output logic             r_done,
  output logic             r_found,
  output logic [CAR_W-1:0] r_data
);

  localparam logic [1:0] OP_NTH = 2'b00;
  localparam logic [1:0] OP_LEN = 2'b01;
  localparam logic [1:0] OP_MEM = 2'b10;
  localparam logic [1:0] OP_GET = 2'b11;

  logic [ENTRIES-1:0] vld;
  logic [CAR_W-1:0]   car_q [ENTRIES];
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [NUM_W-1:0]   num_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (wr_en) vld[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      car_q[wr_idx] <= wr_car;
      tag_q[wr_idx] <= wr_tag;
      num_q[wr_idx] <= wr_num;
    end
  end

  // parallel tag compare and head search
  logic [ENTRIES-1:0] tag_hit;
  logic               any_tag;
  logic [NUM_W-1:0]   max_num;
  logic [LEN_W-1:0]   len;

  always_comb begin
    any_tag = 1'b0;
    max_num = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      tag_hit[e] = vld[e] && (tag_q[e] == q_tag);
      if (tag_hit[e]) begin
        if (!any_tag || num_q[e] > max_num) max_num = num_q[e];
        any_tag = 1'b1;
      end
    end
    len = any_tag ? LEN_W'(max_num) + LEN_W'(1) : '0;
  end

  // nth: convert head index to reverse position
  logic             nth_ok, nth_hit;
  logic [NUM_W-1:0] nth_tgt;
  logic [CAR_W-1:0] nth_car;

  always_comb begin
    nth_ok  = any_tag && (q_arg < CAR_W'(len));
    nth_tgt = max_num - q_arg[NUM_W-1:0];
    nth_hit = 1'b0;
    nth_car = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (nth_ok && !nth_hit && tag_hit[e] && num_q[e] == nth_tgt) begin
        nth_hit = 1'b1;
        nth_car = car_q[e];
      end
    end
  end

  // key match for memq and get, nearest to head wins
  logic             key_hit;
  logic [NUM_W-1:0] key_num;

  always_comb begin
    key_hit = 1'b0;
    key_num = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (tag_hit[e] && car_q[e] == q_arg &&
          (q_op != OP_GET || (max_num[0] == num_q[e][0])) &&
          (!key_hit || num_q[e] > key_num)) begin
        key_hit = 1'b1;
        key_num = num_q[e];
      end
    end
  end

  // get: value sits one position below the key
  logic             val_hit;
  logic [CAR_W-1:0] val_car;

  always_comb begin
    val_hit = 1'b0;
    val_car = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!val_hit && key_hit && key_num != '0 && tag_hit[e] &&
          num_q[e] == key_num - NUM_W'(1)) begin
        val_hit = 1'b1;
        val_car = car_q[e];
      end
    end
  end

  logic             s_found;
  logic [CAR_W-1:0] s_data;

  always_comb begin
    unique case (q_op)
      OP_NTH: begin s_found = nth_hit; s_data = nth_car;                      end
      OP_LEN: begin s_found = any_tag; s_data = CAR_W'(len);                  end
      OP_MEM: begin s_found = key_hit; s_data = CAR_W'(max_num - key_num);    end
      default: begin s_found = val_hit; s_data = val_car;                     end
    endcase
    if (!s_found) s_data = '0;
  end

  logic             st_v, st_found;
  logic [CAR_W-1:0] st_data;
  logic [1:0]       st_op, r_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v <= 1'b0; st_found <= 1'b0; st_data <= '0; st_op <= '0;
      r_done <= 1'b0; r_found <= 1'b0; r_data <= '0; r_op <= '0;
    end else begin
      st_v     <= q_start;
      st_found <= q_start && s_found;
      st_data  <= q_start ? s_data : '0;
      st_op    <= q_op;
      r_done   <= st_v;
      r_found  <= st_found;
      r_data   <= st_data;
      r_op     <= st_op;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (vld == '0));

  assert_write_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vld[$past(wr_idx)] == $past(wr_valid)));

  assert_done_after_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_start |=> ##1 r_done);

  assert_done_needs_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    r_done |-> $past(q_start, 2));

  assert_length_found_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (r_done && r_op == OP_LEN) |-> (r_found == (r_data != '0)));

  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (r_done && !r_found) |-> (r_data == '0));

endmodule

// File: tb/lnode_cam_tb.sv
module lnode_cam_tb_top;
  localparam int CLK_P = 10;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_valid = 0, q_start = 0;
  logic [3:0]  wr_idx = 0, wr_num = 0;
  logic [15:0] wr_car = 0, q_arg = 0;
  logic [5:0]  wr_tag = 0, q_tag = 0;
  logic [1:0]  q_op = 0;
  logic r_done, r_found;
  logic [15:0] r_data;

  int checks = 0, errors = 0;

  logic        m_v [N];
  logic [15:0] m_c [N];
  logic [5:0]  m_t [N];
  logic [3:0]  m_n [N];

  always #(CLK_P/2) clk = ~clk;

  lnode_cam dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_valid(wr_valid),
    .wr_idx(wr_idx), .wr_car(wr_car), .wr_tag(wr_tag), .wr_num(wr_num),
    .q_start(q_start), .q_op(q_op), .q_tag(q_tag), .q_arg(q_arg),
    .r_done(r_done), .r_found(r_found), .r_data(r_data));

  function automatic void expect_q(input logic [1:0] op, input logic [5:0] tg,
                                   input logic [15:0] a, output logic f, output logic [15:0] d);
    int len = 0, best = -1, idx;
    f = 0; d = 0;
    for (int e = 0; e < N; e++)
      if (m_v[e] && m_t[e] == tg && int'(m_n[e]) + 1 > len) len = int'(m_n[e]) + 1;
    case (op)
      2'b00: if (int'(a) < len) begin
        idx = len - 1 - int'(a);
        for (int e = N-1; e >= 0; e--)
          if (m_v[e] && m_t[e] == tg && int'(m_n[e]) == idx) begin f = 1; d = m_c[e]; end
      end
      2'b01: begin f = (len > 0); d = 16'(len); end
      default: begin
        for (int e = 0; e < N; e++)
          if (m_v[e] && m_t[e] == tg && m_c[e] == a && int'(m_n[e]) > best &&
              (op == 2'b10 || ((len - 1 - int'(m_n[e])) % 2 == 0)))
            best = int'(m_n[e]);
        if (op == 2'b10) begin
          if (best >= 0) begin f = 1; d = 16'(len - 1 - best); end
        end else if (best > 0) begin
          for (int e = N-1; e >= 0; e--)
            if (m_v[e] && m_t[e] == tg && int'(m_n[e]) == best - 1) begin f = 1; d = m_c[e]; end
        end
      end
    endcase
  endfunction

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic v, input logic [15:0] c,
                    input logic [5:0] t, input logic [3:0] n);
    wr_en = 1; wr_valid = v; wr_idx = 4'(i); wr_car = c; wr_tag = t; wr_num = n;
    @(negedge clk);
    wr_en = 0;
    m_v[i] = v; m_c[i] = c; m_t[i] = t; m_n[i] = n;
  endtask

  task automatic query(input string req, input logic [1:0] op, input logic [5:0] tg,
                       input logic [15:0] a);
    logic f; logic [15:0] d;
    expect_q(op, tg, a, f, d);
    q_start = 1; q_op = op; q_tag = tg; q_arg = a;
    @(negedge clk);
    q_start = 0;
    chk({req, "/R3 early"}, {16'h0, r_done}, 17'h0);
    @(negedge clk);
    chk({req, "/R3 done"}, {16'h0, r_done}, 17'h1);
    chk(req, {r_found, r_data}, {f, d});
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p;
    void'($urandom(32'd4242));
    for (int e = 0; e < N; e++) begin m_v[e] = 0; m_c[e] = 0; m_t[e] = 0; m_n[e] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 done idle", {16'h0, r_done}, 17'h0);
    rst_n = 1;
    @(negedge clk);
    query("R1 empty length", 2'b01, 6'd1, 16'd0);
    query("R1 empty memq", 2'b10, 6'd1, 16'd0);

    // directed list tag 9, head to tail: 3 7 3 5
    wr(12, 1, 16'd3, 6'd9, 4'd3);
    wr(13, 1, 16'd7, 6'd9, 4'd2);
    wr(14, 1, 16'd3, 6'd9, 4'd1);
    wr(15, 1, 16'd5, 6'd9, 4'd0);
    query("R2 R5 length four", 2'b01, 6'd9, 16'd0);
    query("R4 nth head", 2'b00, 6'd9, 16'd0);
    query("R4 nth tail", 2'b00, 6'd9, 16'd3);
    query("R4 nth index equals length", 2'b00, 6'd9, 16'd4);
    query("R6 memq nearest", 2'b10, 6'd9, 16'd3);
    query("R6 memq absent", 2'b10, 6'd9, 16'd8);
    query("R7 get even key", 2'b11, 6'd9, 16'd3);
    query("R7 get odd key", 2'b11, 6'd9, 16'd7);
    query("R7 get last odd", 2'b11, 6'd9, 16'd5);
    query("R8 other tag", 2'b01, 6'd8, 16'd0);
    wr(12, 0, 16'd3, 6'd9, 4'd3);
    query("R8 invalid head length", 2'b01, 6'd9, 16'd0);
    query("R8 get after shift", 2'b11, 6'd9, 16'd7);
    query("R7 key on last node", 2'b11, 6'd9, 16'd5);
    query("R9 nth miss", 2'b00, 6'd9, 16'd3);

    // random lists in slots 0..11
    p = 0;
    for (int t = 1; t <= 4; t++) begin
      int len = 1 + int'($urandom % 3);
      for (int k = 0; k < len; k++) begin
        wr(p, 1, 16'($urandom % 5), 6'(t), 4'(len - 1 - k));
        p++;
      end
    end
    for (int q = 0; q < 300; q++) begin
      logic [1:0] op = 2'($urandom % 4);
      logic [5:0] tg = 6'($urandom % 6);
      logic [15:0] a = (op == 2'b00) ? 16'($urandom % 5) : 16'($urandom % 6);
      case (op)
        2'b00: query("R4 random nth", op, tg, a);
        2'b01: query("R5 random length", op, tg, a);
        2'b10: query("R6 random memq", op, tg, a);
        default: query("R7 random get", op, tg, a);
      endcase
    end
    // rewrite a slot to another tag
    wr(0, 1, 16'd4, 6'd5, 4'd0);
    query("R2 R8 retagged", 2'b10, 6'd5, 16'd4);
    query("R5 retagged length", 2'b01, 6'd5, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule